// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a slow, always-on clock domain. A counter advances once for each cycle in which the tick-enable input is high. The tick normally arrives at about 31.25 kHz. The counter value is shifted right by a programmable amount to give a scaled count. When the scaled count reaches a 16-bit threshold, the block raises a sticky pending flag, which also drives the interrupt output. If reset generation is enabled, a reset request follows. Software keeps the watchdog from expiring by writing a magic word to the feed register.

Every register is guarded by a one-shot unlock. A write of the key word arms the block for exactly one following register write. Any write that arrives while the block is not armed is dropped. Counting can run all the time, or only while the core-awake input is high. The counter can also restart from zero on each threshold hit, which makes the block a periodic interrupt source.

Top module: `keyed_wdt`

## Requirements
- R1: After reset: config reads 0, count reads 0, compare reads 0xFFFF, the block is not armed, and `irq` and `rst_req` are low.
- R2: A write of 0x0051F15E to offset 0x1C arms the block for one write. A write to any other offset is accepted only while armed. Every non-key write disarms, whether or not it was accepted, including a write to a read-only offset. A key write with any other value disarms.
- R3: An accepted write of 0x0D09F00D to offset 0x18 clears the counter. An accepted feed write of any other value leaves the counter unchanged.
- R4: Offset 0x10 is read-only and returns the counter shifted right by the scale held in config bits [3:0]. Offset 0x08 returns the counter, and an accepted write to it loads the counter from data bits [30:0].
- R5: Compare at offset 0x20 is 16 bits wide. Data bits [31:16] are dropped on write and read back as zero.
- R6: Pending, config bit 28, is set in the cycle after the scaled count is at or above compare. It stays set until software writes config, and `irq` equals it.
- R7: `rst_req` is high exactly while pending and config bit 8 are both set.
- R8: With config bit 9 set, the counter is zero in the cycle after the scaled count meets compare.
- R9: The counter advances by one per tick when config bit 12 is set, or when config bit 13 is set and `core_awake` is high. Otherwise it holds.
- R10: An accepted config write with bit 28 clear clears pending, provided the scaled count is below compare.
- R11: The counter is 31 bits wide and stays at 0x7FFFFFFF instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timebase enable |
| core_awake | input | 1 | High while the core is running |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Pending interrupt |
| rst_req | output | 1 | Reset request |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable whenever `bus_wr` is high. They also assume that ticks are single-cycle pulses. The bench drives every input on the falling edge and holds writes for exactly one rising edge. It stops ticking before it samples any output, so that the counter, the scaled count and the pending flag have settled. The main sweep loads a small set of scales and thresholds. For each pair it steps the tick count just below, at and just above the threshold shifted left by the scale, and computes the expected scaled count and flag values arithmetically.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CFG  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_SCNT = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_FEED = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_KEY  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_CMP  = 6'h20;

    localparam logic [DATA_W-1:0] KEY_WORD  = 32'h0051_F15E;
    localparam logic [DATA_W-1:0] FEED_WORD = 32'h0D09_F00D;

    localparam int unsigned B_RSTEN = 8;
    localparam int unsigned B_ZERO  = 9;
    localparam int unsigned B_ALW   = 12;
    localparam int unsigned B_AWAKE = 13;
    localparam int unsigned B_PEND  = 28;

    typedef struct packed {
        logic rst_en;
        logic zero_on_hit;
        logic run_always;
        logic run_awake;
        logic pend;
    } ctl_t;
endpackage

// File: rtl/kwdt_regs.sv
`timescale 1ns/1ps
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int unsigned SCALE_W = 4,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned CNT_W   = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                hit,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [CNT_W-1:0]    scaled,
    output ctl_t                ctl,
    output logic [SCALE_W-1:0]  scale,
    output logic [CMP_W-1:0]    cmp,
    output logic                feed_clr,
    output logic                cnt_load,
    output logic [CNT_W-1:0]    cnt_load_val
);
    localparam int unsigned CNT_PAD = DATA_W - CNT_W;
    localparam int unsigned CMP_PAD = DATA_W - CMP_W;

    typedef struct packed {
        logic               armed;
        ctl_t               ctl;
        logic [SCALE_W-1:0] scale;
        logic [CMP_W-1:0]   cmp;
    } st_t;

    st_t  s_d, s_q;
    logic wr_key, wr_ok, cfg_wr;

    always_comb begin
        s_d    = s_q;
        wr_key = bus_wr && (bus_addr == OFF_KEY);
        wr_ok  = bus_wr && !wr_key && s_q.armed;
        cfg_wr = wr_ok && (bus_addr == OFF_CFG);

        if (bus_wr) begin
            s_d.armed = wr_key && (bus_wdata == KEY_WORD);
        end

        s_d.ctl.pend = s_q.ctl.pend | hit;

        if (cfg_wr) begin
            s_d.scale           = bus_wdata[SCALE_W-1:0];
            s_d.ctl.rst_en      = bus_wdata[B_RSTEN];
            s_d.ctl.zero_on_hit = bus_wdata[B_ZERO];
            s_d.ctl.run_always  = bus_wdata[B_ALW];
            s_d.ctl.run_awake   = bus_wdata[B_AWAKE];
            s_d.ctl.pend        = bus_wdata[B_PEND];
        end

        if (wr_ok && (bus_addr == OFF_CMP)) begin
            s_d.cmp = bus_wdata[CMP_W-1:0];
        end
    end

    always_comb begin
        feed_clr     = wr_ok && (bus_addr == OFF_FEED) && (bus_wdata == FEED_WORD);
        cnt_load     = wr_ok && (bus_addr == OFF_CNT);
        cnt_load_val = bus_wdata[CNT_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CFG: begin
                bus_rdata[SCALE_W-1:0] = s_q.scale;
                bus_rdata[B_RSTEN]     = s_q.ctl.rst_en;
                bus_rdata[B_ZERO]      = s_q.ctl.zero_on_hit;
                bus_rdata[B_ALW]       = s_q.ctl.run_always;
                bus_rdata[B_AWAKE]     = s_q.ctl.run_awake;
                bus_rdata[B_PEND]      = s_q.ctl.pend;
            end
            OFF_CNT:  bus_rdata = {{CNT_PAD{1'b0}}, cnt};
            OFF_SCNT: bus_rdata = {{CNT_PAD{1'b0}}, scaled};
            OFF_CMP:  bus_rdata = {{CMP_PAD{1'b0}}, s_q.cmp};
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cmp   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl   = s_q.ctl;
    assign scale = s_q.scale;
    assign cmp   = s_q.cmp;

    // R2
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFF_KEY) |=> !s_q.armed);

    // R2
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CMP && !s_q.armed) |=> $stable(s_q.cmp));

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cfg_wr) |=> s_q.ctl.pend);

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctl.pend && !cfg_wr) |=> s_q.ctl.pend);
endmodule

// File: rtl/kwdt_counter.sv
`timescale 1ns/1ps
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int unsigned SCALE_W = 4,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned CNT_W   = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               core_awake,
    input  ctl_t               ctl,
    input  logic [SCALE_W-1:0] scale,
    input  logic [CMP_W-1:0]   cmp,
    input  logic               feed_clr,
    input  logic               cnt_load,
    input  logic [CNT_W-1:0]   cnt_load_val,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   scaled,
    output logic               hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int unsigned      EXT_W   = CNT_W - CMP_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  s_d, s_q;
    logic run;

    always_comb begin
        s_d    = s_q;
        scaled = s_q.cnt >> scale;
        hit    = scaled >= {{EXT_W{1'b0}}, cmp};
        run    = tick && (ctl.run_always || (ctl.run_awake && core_awake));

        if (cnt_load) begin
            s_d.cnt = cnt_load_val;
        end else if (feed_clr || (ctl.zero_on_hit && hit)) begin
            s_d.cnt = '0;
        end else if (run && (s_q.cnt != CNT_MAX)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !cnt_load && !feed_clr && !(ctl.zero_on_hit && hit))
        |=> s_q.cnt == CNT_MAX);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_load && !feed_clr && !(ctl.zero_on_hit && hit))
        |=> $stable(s_q.cnt));

    // R8
    zero_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.zero_on_hit && hit && !cnt_load) |=> s_q.cnt == '0);
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int unsigned SCALE_W = 4,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned CNT_W   = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        core_awake,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        rst_req
);
    ctl_t               ctl;
    logic [SCALE_W-1:0] scale;
    logic [CMP_W-1:0]   cmp;
    logic               feed_clr, cnt_load, hit;
    logic [CNT_W-1:0]   cnt_load_val, cnt, scaled;

    kwdt_regs #(.SCALE_W(SCALE_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hit(hit), .cnt(cnt), .scaled(scaled),
        .ctl(ctl), .scale(scale), .cmp(cmp),
        .feed_clr(feed_clr), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val)
    );

    kwdt_counter #(.SCALE_W(SCALE_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .core_awake(core_awake),
        .ctl(ctl), .scale(scale), .cmp(cmp),
        .feed_clr(feed_clr), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .cnt(cnt), .scaled(scaled), .hit(hit)
    );

    assign irq     = ctl.pend;
    assign rst_req = ctl.pend & ctl.rst_en;

    // R7
    rst_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> irq);
endmodule

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        core_awake = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [5:0]  A_CFG = 6'h00, A_CNT = 6'h08, A_SCNT = 6'h10;
    localparam logic [5:0]  A_FEED = 6'h18, A_KEY = 6'h1C, A_CMP = 6'h20;
    localparam logic [31:0] KEYV = 32'h0051_F15E, FOOD = 32'h0D09_F00D;
    localparam logic [31:0] C_RST = 32'h100, C_ZERO = 32'h200;
    localparam logic [31:0] C_ALW = 32'h1000, C_AWK = 32'h2000, C_PEND = 32'h1000_0000;

    always #2.5 clk = ~clk;

    keyed_wdt u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .core_awake(core_awake),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic kwr(input logic [5:0] a, input logic [31:0] d);
        wr(A_KEY, KEYV);
        wr(a, d);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic outs(input string req, input logic ei, input logic er);
        @(negedge clk);
        #1;
        chk(req, {31'd0, irq}, {31'd0, ei});
        chk(req, {31'd0, rst_req}, {31'd0, er});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CFG, v);  chk("R1 cfg", v, 32'h0);
        rd(A_CNT, v);  chk("R1 cnt", v, 32'h0);
        rd(A_CMP, v);  chk("R1 cmp", v, 32'h0000_FFFF);
        outs("R1 outputs", 1'b0, 1'b0);
        wr(A_CMP, 32'h5);
        rd(A_CMP, v);  chk("R1 not armed", v, 32'h0000_FFFF);

        // R2 one-shot arming
        wr(A_KEY, KEYV); wr(A_CMP, 32'h7); wr(A_CMP, 32'h9);
        rd(A_CMP, v);  chk("R2 single write", v, 32'h7);
        wr(A_KEY, KEYV); wr(A_SCNT, 32'h1); wr(A_CMP, 32'hA);
        rd(A_CMP, v);  chk("R2 read-only write disarms", v, 32'h7);
        wr(A_KEY, 32'h0051_F15F); wr(A_CMP, 32'hB);
        rd(A_CMP, v);  chk("R2 wrong key", v, 32'h7);

        // R5 compare width
        kwr(A_CMP, 32'hABCD_1234);
        rd(A_CMP, v);  chk("R5 cmp upper dropped", v, 32'h1234);

        // R4 count write, R3 feed
        kwr(A_CNT, 32'h8000_0123);
        rd(A_CNT, v);  chk("R4 count load", v, 32'h123);
        kwr(A_FEED, 32'h0D09_F00E);
        rd(A_CNT, v);  chk("R3 bad feed ignored", v, 32'h123);
        kwr(A_FEED, FOOD);
        rd(A_CNT, v);  chk("R3 feed clears", v, 32'h0);
        wr(A_FEED, 32'h0); kwr(A_CNT, 32'h40); wr(A_FEED, FOOD);
        rd(A_CNT, v);  chk("R3 unarmed feed dropped", v, 32'h40);

        // R9 enables
        kwr(A_CMP, 32'hFFFF);
        kwr(A_FEED, FOOD);
        kwr(A_CFG, C_AWK);
        rd(A_CFG, v);  chk("R9 cfg readback", v, C_AWK);
        core_awake = 1'b0; ticks(5);
        rd(A_CNT, v);  chk("R9 asleep holds", v, 32'h0);
        core_awake = 1'b1; ticks(5);
        rd(A_CNT, v);  chk("R9 awake counts", v, 32'h5);
        kwr(A_CFG, 32'h0); ticks(3);
        rd(A_CNT, v);  chk("R9 disabled holds", v, 32'h5);
        core_awake = 1'b0;

        // R4 R6 R7 sweep over scale, compare and tick count
        for (int s = 0; s < 4; s++) begin
            for (int c = 1; c < 5; c++) begin
                for (int dk = -1; dk < 2; dk++) begin
                    int k;
                    logic ei, er;
                    logic [31:0] cfgv;
                    k = (c << s) + dk;
                    cfgv = 32'(s) | ((s % 2 == 1) ? C_RST : 32'h0);
                    kwr(A_CMP, 32'(c));
                    kwr(A_CFG, cfgv);
                    kwr(A_FEED, FOOD);
                    kwr(A_CFG, cfgv | C_ALW);
                    ticks(k);
                    rd(A_CNT, v);  chk("R9 sweep count", v, 32'(k));
                    rd(A_SCNT, v); chk("R4 scaled", v, 32'(k >> s));
                    ei = ((k >> s) >= c);
                    er = ei && (s % 2 == 1);
                    outs("R6 R7 flags", ei, er);
                    rd(A_CFG, v);  chk("R6 pend bit", v & C_PEND, ei ? C_PEND : 32'h0);
                end
            end
        end

        // R8 zero on hit, R10 clear pending
        kwr(A_CMP, 32'h3);
        kwr(A_CFG, 32'h0);
        kwr(A_FEED, FOOD);
        kwr(A_CFG, C_ZERO | C_ALW | C_RST);
        ticks(2);
        rd(A_CNT, v);  chk("R8 below threshold", v, 32'h2);
        outs("R8 no flag yet", 1'b0, 1'b0);
        ticks(1);
        rd(A_CNT, v);  chk("R8 wrapped to zero", v, 32'h0);
        outs("R8 flag set", 1'b1, 1'b1);
        kwr(A_CFG, C_ZERO | C_ALW | C_RST);
        outs("R10 pending cleared", 1'b0, 1'b0);
        kwr(A_CFG, C_ALW | C_PEND);
        outs("R10 pend written one", 1'b1, 1'b0);

        // R11 saturation
        kwr(A_CFG, C_ALW);
        kwr(A_CNT, 32'h7FFF_FFFE);
        ticks(3);
        rd(A_CNT, v);  chk("R11 saturate", v, 32'h7FFF_FFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule